// File: doc/BRIEF.md
# Timed Challenge Response Checker

This block runs one timed challenge round against a host processor. Before a round, local control logic loads an expected answer, a deadline measured in clock cycles and a wait period. The block then raises an interrupt to tell the host that a challenge is ready, and it counts cycles until the host writes its answer. The answer is judged on two things: its value and its arrival time. A correct value that arrives after the deadline is still flagged, because a slow answer may point to emulation, virtualization or a stalled path. The expected answer is held only inside the block and has no read path to the host.

After the deadline the block keeps listening for a grace window of `GRACE` cycles. A write inside that window is classed as late. When the window closes with no write, the round is classed as a timeout. The verdict is shown for one cycle. The block then counts the programmed wait period and returns to idle, ready for the next load. The wait and deadline counters are 33 bits wide. At a 200 MHz clock this covers periods of 100 ms, 1 s and 5 s.

Top module: `chal_deadline_chk`

## Requirements
- R1: While idle, a `ld_vld` pulse captures `ld_sol`, `ld_limit` and `wait_cycles`. From the next cycle on, `irq` and `busy` are 1.
- R2: The elapsed count is 0 in the first cycle after the load and rises by one each cycle. `irq` stays 1 while the count is at most `ld_limit` and no write has been seen. It drops the cycle after a host write, or the cycle after the count passes the limit.
- R3: A first write with `hw_data` equal to the loaded answer, sampled while the count is at most `ld_limit`, gives `pass`=1, `alarm`=0 and `fail_code`=0 (2'd0). The deadline cycle itself counts as on time.
- R4: A first write sampled while the count is above `ld_limit` (up to `ld_limit`+`GRACE`) gives `alarm`=1 and `fail_code`=2 (late). This holds whatever the value written.
- R5: An on-time first write whose value differs from the loaded answer gives `alarm`=1 and `fail_code`=1 (wrong value).
- R6: If no write has arrived when the count reaches `ld_limit`+`GRACE`, the block gives `alarm`=1 and `fail_code`=3 (timeout).
- R7: Only the first write of a round is judged. Further writes in the same round leave the verdict unchanged.
- R8: The verdict appears two cycles after the deciding edge. `pass` and `alarm` are never high together, and each is high for exactly one cycle per round.
- R9: After the verdict cycle the block waits max(`wait_cycles`,1) cycles, then lowers `busy`.
- R10: A `ld_vld` pulse while `busy` is 1 is ignored. It does not raise `irq` or start a round.
- R11: While `rst` is 1, `irq`, `pass`, `alarm`, `busy` and `fail_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_vld | input | 1 | Load strobe for a new round |
| ld_sol | input | 32 | Expected answer value |
| ld_limit | input | 32 | Deadline in cycles |
| wait_cycles | input | 32 | Wait period after the verdict |
| hw_we | input | 1 | Host write strobe to the answer register |
| hw_data | input | 32 | Host answer data |
| irq | output | 1 | Challenge-ready interrupt |
| pass | output | 1 | Round passed (one cycle) |
| alarm | output | 1 | Round failed (one cycle) |
| fail_code | output | 2 | 0 ok, 1 wrong value, 2 late, 3 timeout |
| busy | output | 1 | Round or wait period in progress |

## Verification
The hardest case to reach from the ports is the edge between deadline and grace. There are three distinct verdicts there. A write at exactly the limit is on time. A write one cycle later is late. A write in the last grace cycle is still late rather than a timeout. The bench reaches these by counting falling edges from the load pulse, so that the host strobe is sampled at a chosen elapsed count. It repeats the round with correct and wrong values so that the late and wrong-value cases are told apart. It issues a second write straight after the first, and a load pulse during the wait period, to show that both are ignored.

// File: rtl/chal_pkg.sv
package chal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_CHECK, ST_REPORT, ST_WAIT
  } chk_state_t;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0, FC_WRONG = 2'd1, FC_LATE = 2'd2, FC_TIMEOUT = 2'd3
  } fail_code_t;
endpackage

// File: rtl/chal_timer.sv
module chal_timer #(
  parameter int CW = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chal_capture.sv
module chal_capture #(
  parameter int DW = 32,
  parameter int CW = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          smp,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] expect_val,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] lim,
  output logic          seen,
  output logic          val_ok,
  output logic          on_time
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen    <= 1'b0;
      val_ok  <= 1'b0;
      on_time <= 1'b0;
    end else if (smp && !seen) begin
      seen    <= 1'b1;
      val_ok  <= (data == expect_val);
      on_time <= (cnt <= lim);
    end
  end

  // R7
  first_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !clr) |=> ($stable(val_ok) && $stable(on_time)));
endmodule

// File: rtl/chal_seq.sv
module chal_seq
  import chal_pkg::*;
#(
  parameter int CW    = 33,
  parameter int GRACE = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_vld,
  input  logic          hw_we,
  input  logic [CW-1:0] el_cnt,
  input  logic [CW-1:0] lim,
  input  logic [CW-1:0] wt_cnt,
  input  logic [CW-1:0] wt_lim,
  input  logic          seen,
  input  logic          val_ok,
  input  logic          on_time,
  output chk_state_t    st,
  output logic          irq,
  output logic          pass,
  output logic          alarm,
  output logic [1:0]    code,
  output logic          busy
);
  localparam logic [CW-1:0] GR = CW'(GRACE);

  chk_state_t    nxt;
  logic [CW-1:0] lim_end;
  logic          expired;
  logic          wait_done;
  logic          good;
  fail_code_t    verdict;

  assign lim_end   = lim + GR;
  assign expired   = (el_cnt == lim_end);
  assign wait_done = ((wt_cnt + 1'b1) >= wt_lim);
  assign good      = seen && val_ok && on_time;

  always_comb begin
    if (!seen)        verdict = FC_TIMEOUT;
    else if (!on_time) verdict = FC_LATE;
    else if (!val_ok)  verdict = FC_WRONG;
    else               verdict = FC_NONE;
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:   if (ld_vld) nxt = ST_ARMED;
      ST_ARMED:  if (hw_we || expired) nxt = ST_CHECK;
      ST_CHECK:  nxt = ST_REPORT;
      ST_REPORT: nxt = ST_WAIT;
      ST_WAIT:   if (wait_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      irq   <= 1'b0;
      pass  <= 1'b0;
      alarm <= 1'b0;
      code  <= 2'd0;
      busy  <= 1'b0;
    end else begin
      st   <= nxt;
      busy <= (nxt != ST_IDLE);
      case (st)
        ST_IDLE:  irq <= ld_vld;
        ST_ARMED: irq <= !hw_we && (el_cnt < lim);
        default:  irq <= 1'b0;
      endcase
      pass  <= (st == ST_CHECK) && good;
      alarm <= (st == ST_CHECK) && !good;
      code  <= (st == ST_CHECK) ? verdict : FC_NONE;
    end
  end

  // R8
  pass_alarm_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass && alarm));
  // R8
  verdict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (pass || alarm) |=> !(pass || alarm));
  // R2
  irq_in_round_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (st == ST_ARMED));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARMED) |-> (el_cnt <= lim_end));
  // R10
  load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && ld_vld) |=> (st != ST_ARMED));
endmodule

// File: rtl/chal_deadline_chk.sv
module chal_deadline_chk
  import chal_pkg::*;
#(
  parameter int DW    = 32,
  parameter int TW    = 32,
  parameter int GRACE = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_vld,
  input  logic [DW-1:0] ld_sol,
  input  logic [TW-1:0] ld_limit,
  input  logic [TW-1:0] wait_cycles,
  input  logic          hw_we,
  input  logic [DW-1:0] hw_data,
  output logic          irq,
  output logic          pass,
  output logic          alarm,
  output logic [1:0]    fail_code,
  output logic          busy
);
  localparam int CW = TW + 1;

  chk_state_t    st;
  logic [DW-1:0] sol_q;
  logic [CW-1:0] lim_q, wt_q, el_cnt, wt_cnt;
  logic          seen, val_ok, on_time;

  always_ff @(posedge clk) begin
    if (rst) begin
      sol_q <= '0;
      lim_q <= '0;
      wt_q  <= '0;
    end else if (st == ST_IDLE && ld_vld) begin
      sol_q <= ld_sol;
      lim_q <= {1'b0, ld_limit};
      wt_q  <= {1'b0, wait_cycles};
    end
  end

  chal_timer #(.CW(CW)) u_elapsed (
    .clk(clk), .rst(rst), .clr(st != ST_ARMED), .en(st == ST_ARMED), .cnt(el_cnt)
  );

  chal_timer #(.CW(CW)) u_wait (
    .clk(clk), .rst(rst), .clr(st != ST_WAIT), .en(st == ST_WAIT), .cnt(wt_cnt)
  );

  chal_capture #(.DW(DW), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .clr(st == ST_IDLE),
    .smp(st == ST_ARMED && hw_we), .data(hw_data), .expect_val(sol_q),
    .cnt(el_cnt), .lim(lim_q),
    .seen(seen), .val_ok(val_ok), .on_time(on_time)
  );

  chal_seq #(.CW(CW), .GRACE(GRACE)) u_seq (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .hw_we(hw_we),
    .el_cnt(el_cnt), .lim(lim_q), .wt_cnt(wt_cnt), .wt_lim(wt_q),
    .seen(seen), .val_ok(val_ok), .on_time(on_time),
    .st(st), .irq(irq), .pass(pass), .alarm(alarm), .code(fail_code), .busy(busy)
  );
endmodule

// File: tb/chal_deadline_chk_tb.sv
`timescale 1ns/1ps
module chal_deadline_chk_tb;
  localparam int G = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_vld = 1'b0;
  logic [31:0] ld_sol = '0, ld_limit = '0, wait_cycles = '0;
  logic        hw_we = 1'b0;
  logic [31:0] hw_data = '0;
  logic        irq, pass, alarm, busy;
  logic [1:0]  fail_code;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  chal_deadline_chk u_dut (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_sol(ld_sol), .ld_limit(ld_limit),
    .wait_cycles(wait_cycles), .hw_we(hw_we), .hw_data(hw_data),
    .irq(irq), .pass(pass), .alarm(alarm), .fail_code(fail_code), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected verdict for every verdict cycle (R3 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (!rst && (pass || alarm)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected verdict", {pass, alarm, fail_code}, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(fail_code == 2'(e), "R3/R4/R5/R6/R7 fail_code", fail_code, e);
        chk(pass == (e == 0) && alarm == (e != 0), "R8 pass/alarm", {pass, alarm},
            (e == 0) ? 2 : 1);
      end
    end
  end

  task automatic run_round(input logic [31:0] sol, input int lim, input int wt,
                           input int wr_at, input logic [31:0] wdat, input int exp_code);
    int n, m, wexp;
    @(negedge clk);
    ld_vld = 1'b1; ld_sol = sol; ld_limit = 32'(lim); wait_cycles = 32'(wt);
    @(negedge clk);
    ld_vld = 1'b0; ld_sol = 32'h0; ld_limit = 32'h0; wait_cycles = 32'h0;
    chk(irq && busy, "R1 irq/busy after load", {irq, busy}, 3);
    exp_q.push_back(exp_code);
    if (wr_at >= 0) begin
      for (int i = 0; i < wr_at; i++) @(negedge clk);
      chk(irq == (wr_at <= lim), "R2 irq level before write", irq, (wr_at <= lim));
      hw_we = 1'b1; hw_data = wdat;
      @(negedge clk);
      chk(!irq, "R2 irq drop after write", irq, 0);
      hw_data = (wdat == sol) ? ~sol : sol;  // R7 second write in same round
      @(negedge clk);
      hw_we = 1'b0;
    end
    n = 0;
    while (!(pass || alarm) && n < 400) begin @(negedge clk); n++; end
    m = 0;
    while (busy && m < 400) begin
      @(negedge clk); m++;
      if (m == 1 && wt >= 3) begin
        ld_vld = 1'b1; ld_sol = sol; ld_limit = 32'd50;
      end
      if (m == 2 && wt >= 3) begin
        ld_vld = 1'b0;
        chk(!irq && busy, "R10 load during wait ignored", {irq, busy}, 1);
      end
    end
    wexp = 1 + ((wt < 1) ? 1 : wt);
    chk(m == wexp, "R9 wait length", m, wexp);
    chk(exp_q.size() == 0, "R8 verdict seen", exp_q.size(), 0);
    @(negedge clk);
    chk(!irq && !busy, "R10 stays idle", {irq, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!irq && !pass && !alarm && !busy && fail_code == 2'd0, "R11 reset state",
        {irq, pass, alarm, busy, fail_code}, 0);
    rst = 1'b0;
    run_round(32'hA5A5_0001, 10, 4, 3,      32'hA5A5_0001, 0);  // R3 early
    run_round(32'hA5A5_0002, 10, 4, 3,      32'h1234_5678, 1);  // R5 wrong, R7 correct follow-up
    run_round(32'hA5A5_0003, 10, 4, 10,     32'hA5A5_0003, 0);  // R3 at deadline
    run_round(32'hA5A5_0004, 10, 4, 11,     32'hA5A5_0004, 2);  // R4 one late
    run_round(32'hA5A5_0005, 10, 4, 11,     32'h0,         2);  // R4 late beats wrong
    run_round(32'hA5A5_0006, 10, 4, 10 + G, 32'hA5A5_0006, 2);  // R4 last grace cycle
    run_round(32'hA5A5_0007, 10, 4, -1,     32'h0,         3);  // R6 timeout
    run_round(32'hA5A5_0008, 0,  0, 0,      32'hA5A5_0008, 0);  // R3 zero limit, R9 zero wait
    run_round(32'hA5A5_0009, 5,  1, 2,      32'hA5A5_0009, 0);  // R9 wait of one
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule